// File: doc/BRIEF.md
# Serial Command Memory Loader

This block turns a stream of bytes from a serial receiver into memory writes and a processor launch. Each command begins with a one-byte opcode. Some opcodes are followed by a payload. The block holds a store pointer that says where the next write lands. A word write stores a full 32-bit value and moves the pointer forward by four. A byte write stores one byte and moves the pointer forward by one. A pointer load sets the pointer to a new address. A run command tells the processor to start executing.

Bytes enter through a valid/ready handshake. Writes leave through a request/acknowledge memory port that carries byte-lane enables. While a write waits for its acknowledge, the loader holds the write steady and stops taking input bytes. The run command produces a one-cycle start pulse. The entry address and the initial stack value are constant outputs set by parameters.

Top module: `cmd_loader`

## Requirements
- R1: After reset, in_ready is 1, mem_req is 0 and run_start is 0. The store pointer is 0, so the first word write after reset targets address 0.
- R2: Opcode 0x00 is followed by four payload bytes, least significant byte first. When the last byte is accepted, mem_req rises in the following cycle with mem_wdata equal to the assembled word and mem_be equal to 4'b1111.
- R3: When a word write is acknowledged, the store pointer increases by 4.
- R4: Opcode 0x01 is followed by four payload bytes, least significant byte first. The assembled value is loaded into the store pointer, and no memory request is made.
- R5: Opcode 0x03 is followed by one payload byte. The resulting request has mem_addr equal to the pointer, mem_wdata holding that byte in all four lanes, and exactly one enable bit set: bit number pointer[1:0]. When the request is acknowledged, the pointer increases by 1.
- R6: Opcode 0x02 takes no payload. It raises run_start for exactly the one cycle after the opcode is accepted. run_pc is 0x00400000, and run_sp equals the STACK_INIT parameter. The store pointer does not change.
- R7: Any opcode from 0x04 to 0xFF is dropped. It produces no request and no start pulse, and the next byte is read as an opcode.
- R8: While mem_req is high and mem_ack is low, in_ready is 0. Over that time mem_req, mem_addr, mem_wdata and mem_be all hold their values, and no input byte is consumed.
- R9: A word write issued at an unaligned pointer drives mem_addr with its low two bits cleared. The pointer still advances by 4 from its unaligned value.
- R10: The pointer wraps modulo 2^32. A byte write at 0xFFFFFFFF enables lane 3, and the byte write after it targets address 0 on lane 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | Input byte is valid |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Loader can accept a byte |
| mem_req | output | 1 | Memory write request, held until acknowledged |
| mem_addr | output | 32 | Write address |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Byte-lane enables |
| mem_ack | input | 1 | Memory accepts the pending write |
| run_start | output | 1 | One-cycle pulse that starts the processor |
| run_pc | output | 32 | Execution entry address |
| run_sp | output | 32 | Initial stack pointer value |

## Verification
The bench uses the default 32-bit data and address widths, so the lane-select arithmetic and the 2^32 pointer wrap are tested at their real size. It sets STACK_INIT to a value other than the default, which shows that the parameter reaches run_sp. The bench sends every opcode value from 0x04 to 0xFF, and it places byte writes on every lane offset, some of them across a word boundary. It also varies the acknowledge latency, which exercises the stall path. One case holds a run opcode on the input during a stall, to show that the byte is taken only after the acknowledge.

// File: rtl/cmdld_pkg.sv
package cmdld_pkg;
  localparam logic [7:0] OPC_WORD = 8'h00;
  localparam logic [7:0] OPC_PTR  = 8'h01;
  localparam logic [7:0] OPC_RUN  = 8'h02;
  localparam logic [7:0] OPC_BYTE = 8'h03;

  typedef enum logic [1:0] {
    ST_OPC = 2'd0,
    ST_PAY = 2'd1,
    ST_MEM = 2'd2
  } ldr_state_t;

  typedef enum logic [1:0] {
    K_WORD = 2'd0,
    K_PTR  = 2'd1,
    K_BYTE = 2'd2
  } cmd_kind_t;
endpackage

// File: rtl/cmdld_parser.sv
module cmdld_parser
  import cmdld_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  output logic              in_ready,
  input  logic              mem_ack,
  output logic              mem_req,
  output logic              is_word,
  output logic [DATA_W-1:0] payload,
  output logic              ptr_load,
  output logic [DATA_W-1:0] ptr_load_val,
  output logic              ptr_step,
  output logic              run_start
);
  localparam int LANES = DATA_W / 8;
  localparam int CNT_W = $clog2(LANES + 1);

  ldr_state_t        state_q, state_d;
  cmd_kind_t         kind_q, kind_d;
  logic [CNT_W-1:0]  rem_q, rem_d;
  logic [DATA_W-1:0] pay_q, pay_d;
  logic              pay_en;
  logic              run_q, run_d;
  logic              accept;

  assign in_ready = (state_q != ST_MEM);
  assign accept   = in_valid && in_ready;
  assign pay_d    = {in_data, pay_q[DATA_W-1:8]};
  assign pay_en   = accept && (state_q == ST_PAY);

  always_comb begin
    state_d  = state_q;
    kind_d   = kind_q;
    rem_d    = rem_q;
    ptr_load = 1'b0;
    ptr_step = 1'b0;
    run_d    = 1'b0;
    case (state_q)
      ST_OPC: begin
        if (accept) begin
          case (in_data)
            OPC_WORD: begin
              state_d = ST_PAY;
              kind_d  = K_WORD;
              rem_d   = CNT_W'(LANES);
            end
            OPC_PTR: begin
              state_d = ST_PAY;
              kind_d  = K_PTR;
              rem_d   = CNT_W'(LANES);
            end
            OPC_BYTE: begin
              state_d = ST_PAY;
              kind_d  = K_BYTE;
              rem_d   = CNT_W'(1);
            end
            OPC_RUN: run_d = 1'b1;
            default: ;
          endcase
        end
      end
      ST_PAY: begin
        if (accept) begin
          rem_d = rem_q - CNT_W'(1);
          if (rem_q == CNT_W'(1)) begin
            if (kind_q == K_PTR) begin
              ptr_load = 1'b1;
              state_d  = ST_OPC;
            end else begin
              state_d = ST_MEM;
            end
          end
        end
      end
      ST_MEM: begin
        if (mem_ack) begin
          ptr_step = 1'b1;
          state_d  = ST_OPC;
        end
      end
      default: state_d = ST_OPC;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_OPC;
      kind_q  <= K_WORD;
      rem_q   <= '0;
      run_q   <= 1'b0;
      pay_q   <= '0;
    end else begin
      state_q <= state_d;
      kind_q  <= kind_d;
      rem_q   <= rem_d;
      run_q   <= run_d;
      if (pay_en) pay_q <= pay_d;
    end
  end

  assign mem_req      = (state_q == ST_MEM);
  assign is_word      = (kind_q == K_WORD);
  assign payload      = pay_q;
  assign ptr_load_val = pay_d;
  assign run_start    = run_q;

  // R7: an unsupported opcode leaves the parser waiting for an opcode
  p_unknown_dropped_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && state_q == ST_OPC && in_data > OPC_BYTE)
      |=> (state_q == ST_OPC && !run_q && !mem_req));

  // R6: a start pulse only ever leaves the parser ready for an opcode
  p_run_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (state_q == ST_OPC));
endmodule

// File: rtl/cmdld_ptr.sv
module cmdld_ptr #(
  parameter int ADDR_W = 32,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              step,
  input  logic              step_word,
  output logic [ADDR_W-1:0] ptr
);
  logic [ADDR_W-1:0] ptr_q, ptr_d, step_amt;
  logic              ptr_en;

  assign step_amt = step_word ? ADDR_W'(LANES) : ADDR_W'(1);
  assign ptr_en   = load || step;

  always_comb begin
    ptr_d = ptr_q;
    if (load)      ptr_d = load_val;
    else if (step) ptr_d = ptr_q + step_amt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end

  assign ptr = ptr_q;

  // R3: a completed word write moves the pointer by one word
  p_word_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && step_word && !load) |=> (ptr_q == $past(ptr_q) + ADDR_W'(LANES)));

  // R5: a completed byte write moves the pointer by one
  p_byte_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !step_word && !load) |=> (ptr_q == $past(ptr_q) + ADDR_W'(1)));
endmodule

// File: rtl/cmdld_wport.sv
module cmdld_wport #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req,
  input  logic                  is_word,
  input  logic [ADDR_W-1:0]     ptr,
  input  logic [DATA_W-1:0]     payload,
  output logic [ADDR_W-1:0]     addr,
  output logic [DATA_W-1:0]     wdata,
  output logic [DATA_W/8-1:0]   be
);
  localparam int LANES = DATA_W / 8;
  localparam int LSB_W = $clog2(LANES);

  logic [7:0] byte_val;
  assign byte_val = payload[DATA_W-1 -: 8];
  assign addr     = is_word ? {ptr[ADDR_W-1:LSB_W], {LSB_W{1'b0}}} : ptr;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign be[g]          = is_word || (ptr[LSB_W-1:0] == LSB_W'(g));
    assign wdata[8*g +: 8] = is_word ? payload[8*g +: 8] : byte_val;
  end

  // R5: a byte write enables a single lane
  p_byte_one_lane_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !is_word) |-> ($countones(be) == 1));

  // R9: word writes always land on an aligned address
  p_word_aligned_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req && is_word) |-> (addr[LSB_W-1:0] == '0 && be == '1));
endmodule

// File: rtl/cmd_loader.sv
module cmd_loader #(
  parameter int          ADDR_W     = 32,
  parameter int          DATA_W     = 32,
  parameter logic [31:0] ENTRY_PC   = 32'h0040_0000,
  parameter logic [31:0] STACK_INIT = 32'h7FFF_FFFC
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [7:0]          in_data,
  output logic                in_ready,
  output logic                mem_req,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [DATA_W-1:0]   mem_wdata,
  output logic [DATA_W/8-1:0] mem_be,
  input  logic                mem_ack,
  output logic                run_start,
  output logic [31:0]         run_pc,
  output logic [31:0]         run_sp
);
  localparam int LANES = DATA_W / 8;

  logic [1:0]        rst_sync_q;
  logic              rst_n_int;
  logic              is_word, ptr_load, ptr_step;
  logic [DATA_W-1:0] payload, ptr_load_val;
  logic [ADDR_W-1:0] ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  cmdld_parser #(.DATA_W(DATA_W)) u_parser (
    .clk(clk), .rst_n(rst_n_int),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .mem_ack(mem_ack), .mem_req(mem_req), .is_word(is_word),
    .payload(payload), .ptr_load(ptr_load), .ptr_load_val(ptr_load_val),
    .ptr_step(ptr_step), .run_start(run_start)
  );

  cmdld_ptr #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ptr (
    .clk(clk), .rst_n(rst_n_int),
    .load(ptr_load), .load_val(ADDR_W'(ptr_load_val)),
    .step(ptr_step), .step_word(is_word), .ptr(ptr)
  );

  cmdld_wport #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wport (
    .clk(clk), .rst_n(rst_n_int),
    .req(mem_req), .is_word(is_word), .ptr(ptr), .payload(payload),
    .addr(mem_addr), .wdata(mem_wdata), .be(mem_be)
  );

  assign run_pc = ENTRY_PC;
  assign run_sp = STACK_INIT;

  // R8: a pending write holds steady until acknowledged
  p_hold_until_ack_r8: assert property (@(posedge clk) disable iff (!rst_n_int)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)
                               && $stable(mem_wdata) && $stable(mem_be)));

  // R8: no byte is taken while a write is pending
  p_stall_input_r8: assert property (@(posedge clk) disable iff (!rst_n_int)
    mem_req |-> !in_ready);

  // R4: a pointer load is never followed by a write request
  p_load_no_write_r4: assert property (@(posedge clk) disable iff (!rst_n_int)
    ptr_load |=> !mem_req);
endmodule

// File: tb/cmd_loader_test.sv
`timescale 1ns/1ps
module cmd_loader_test;
  localparam logic [31:0] SP_VAL = 32'h0000_8FF0;

  logic        clk, rst_n, in_valid, in_ready, mem_req, mem_ack, run_start;
  logic [7:0]  in_data;
  logic [31:0] mem_addr, mem_wdata, run_pc, run_sp;
  logic [3:0]  mem_be;

  int   nchecks = 0;
  int   nerr    = 0;
  bit   done    = 0;
  logic [31:0] mptr;

  cmd_loader #(.STACK_INIT(SP_VAL)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_ack(mem_ack),
    .run_start(run_start), .run_pc(run_pc), .run_sp(run_sp)
  );

  initial clk = 0;
  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchecks++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1; in_data = b;
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic send4(input logic [31:0] w);
    for (int i = 0; i < 4; i++) send(w[8*i +: 8]);
  endtask

  task automatic expect_req(input string tag, input logic [31:0] a,
                            input logic [31:0] d, input logic [3:0] be, input int waitc);
    chk({tag, " req"}, {31'd0, mem_req}, 32'd1);
    chk({tag, " addr"}, mem_addr, a);
    chk({tag, " data"}, mem_wdata, d);
    chk({tag, " be"}, {28'd0, mem_be}, {28'd0, be});
    for (int i = 0; i < waitc; i++) begin
      @(negedge clk);
      chk("R8 ready low", {31'd0, in_ready}, 32'd0);
      chk("R8 addr held", mem_addr, a);
      chk("R8 data held", mem_wdata, d);
    end
    mem_ack = 1;
    @(negedge clk);
    mem_ack = 0;
    chk({tag, " req drop"}, {31'd0, mem_req}, 32'd0);
  endtask

  task automatic cmd_word(input logic [31:0] w, input int waitc);
    send(8'h00); send4(w);
    expect_req("R2", {mptr[31:2], 2'b00}, w, 4'hF, waitc);
    mptr = mptr + 32'd4; // R3
  endtask

  task automatic cmd_byte(input logic [7:0] b, input int waitc);
    send(8'h03); send(b);
    expect_req("R5", mptr, {4{b}}, 4'b0001 << mptr[1:0], waitc);
    mptr = mptr + 32'd1;
  endtask

  task automatic cmd_ptr(input logic [31:0] v);
    send(8'h01); send4(v);
    chk("R4 no write", {31'd0, mem_req}, 32'd0);
    @(negedge clk);
    chk("R4 no write later", {31'd0, mem_req}, 32'd0);
    mptr = v;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchecks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchecks++; nerr++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    rst_n = 0; in_valid = 0; in_data = 0; mem_ack = 0; mptr = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 ready", {31'd0, in_ready}, 32'd1);
    chk("R1 req", {31'd0, mem_req}, 32'd0);
    chk("R1 start", {31'd0, run_start}, 32'd0);
    cmd_word(32'hDEAD_BEEF, 0); // R1: lands at 0
    cmd_word(32'h0102_0304, 3); // R3: lands at 4
    cmd_word(32'hFFFF_0000, 1);

    // R4 pointer load then byte sweep across all lanes (R5)
    cmd_ptr(32'h0000_0040);
    for (int i = 0; i < 8; i++) cmd_byte(8'hA0 + 8'(i), i % 3);
    cmd_word(32'h5555_AAAA, 2);

    // R6 run
    send(8'h02);
    chk("R6 start", {31'd0, run_start}, 32'd1);
    chk("R6 pc", run_pc, 32'h0040_0000);
    chk("R6 sp", run_sp, SP_VAL);
    chk("R6 no req", {31'd0, mem_req}, 32'd0);
    @(negedge clk);
    chk("R6 pulse end", {31'd0, run_start}, 32'd0);
    cmd_byte(8'h11, 0); // R6 pointer unchanged

    // R7 unknown opcode sweep
    for (int op = 4; op < 256; op++) begin
      send(8'(op));
      chk("R7 no start", {31'd0, run_start}, 32'd0);
      chk("R7 no req", {31'd0, mem_req}, 32'd0);
    end
    cmd_byte(8'h22, 1); // R7 next byte read as opcode

    // R8 run byte held on input during a stall
    send(8'h03);
    @(negedge clk);
    in_valid = 1; in_data = 8'h77;
    @(negedge clk);
    in_data = 8'h02;
    repeat (3) begin
      @(negedge clk);
      chk("R8 stall start", {31'd0, run_start}, 32'd0);
      chk("R8 stall ready", {31'd0, in_ready}, 32'd0);
      chk("R8 stall be", {28'd0, mem_be}, {28'd0, 4'b0001 << mptr[1:0]});
    end
    mem_ack = 1;
    @(negedge clk);
    mem_ack = 0;
    chk("R8 start not yet", {31'd0, run_start}, 32'd0);
    @(negedge clk);
    in_valid = 0;
    chk("R8 run after ack", {31'd0, run_start}, 32'd1);
    mptr = mptr + 32'd1;

    // R9 unaligned word write
    cmd_ptr(32'h0000_0102);
    send(8'h00); send4(32'hCAFE_F00D);
    expect_req("R9", 32'h0000_0100, 32'hCAFE_F00D, 4'hF, 1);
    mptr = 32'h0000_0106;
    cmd_byte(8'h3C, 0); // R9 pointer is 0x106

    // R10 wrap
    cmd_ptr(32'hFFFF_FFFF);
    cmd_byte(8'h5A, 0);
    chk("R10 wrapped model", mptr, 32'h0000_0000);
    cmd_byte(8'hC3, 2);

    finish_run();
  end
endmodule